// File: doc/BRIEF.md
# Z80 Extended Bank Mapper

This block sits between a Z80 core and a flat pseudo-static RAM of up to 8MB. It watches I/O writes to a small set of paging ports and converts every 16-bit CPU address into a 23-bit physical address. The physical space is cut into 16KB banks. Banks 0 to 31 are the lower 512KB of RAM. Banks 32 to 63 hold ROM images. Higher banks are reachable only through fast paging.

The mapper supports several paging schemes: the 128K-style memory control port, an all-RAM special mode, and a fast-paging register with a 3-bit high extension. It also provides three control features:
- A bootloader overlay that is active from reset and can be removed once.
- A context switch that maps a custom ROM into the ROM area when the NMI vector is fetched.
- A services-vector trap that software can enable.

The physical address and the overlay chip-enable are combinational from the current CPU address and the registered paging state. Port writes take effect on the next rising clock edge.

Top module: `zxm_bank_mapper`

## Requirements
- R1: After reset, the bootloader overlay is on. A memory access in $0000-$3FFF raises `boot_ce_o`, and an access outside that range does not. The trap is disabled, the context switch is clear and all paging fields are zero.
- R2: In normal mode, the physical address is bank*16384 + addr[13:0]. Segment $4000 maps to bank 5, segment $8000 maps to bank 2, and segment $C000 maps to the bank in bits 2:0 of the last write to port $7FFD.
- R3: In the ROM area, once the overlay is gone and with no context switch in normal mode, the bank is 32 + n. Here n = 2*(bit 2 of port $1FFD) + (bit 4 of port $7FFD).
- R4: Writing port $7FFD with bit 5 set locks the paging. Later writes to $7FFD and $1FFD are ignored until reset.
- R5: Writing port $1FFD with bit 0 set selects special mode. Bits 2:1 pick the banks for segments 0 to 3: 0 gives {0,1,2,3}, 1 gives {4,5,6,7}, 2 gives {4,5,6,3}, and 3 gives {4,7,6,3}.
- R6: Bit 7 of port $54DF enables fast paging, and bits 5:0 give the low bank bits. Bits 2:0 of port $64DF give the high bits. When fast paging is enabled, segment $C000 maps to bank 64*high + low in every mode. When it is disabled, segment $C000 follows R2 or R5.
- R7: Any write to port $44DF removes the overlay. No later write brings it back; only reset does.
- R8: `trap_o` is high during an M1 opcode fetch at $0025 while the trap is enabled. Bit 0 of each write to $44DF sets the enable (so writing $AB turns it on). A non-M1 read at $0025 or a fetch at any other address never raises `trap_o`.
- R9: An M1 fetch at $0066 maps the ROM area to bank 36, starting in that same cycle. The mapping stays until port $34DF is written with bit 0 clear. Writing $34DF with bit 0 set turns it on. A non-M1 read at $0066 does not turn it on.
- R10: The overlay chip-enable outranks every other mapping in the ROM area. Below it, the context switch outranks special and normal mode. A fetch at $0066 while the overlay is on still arms the context switch.
- R11: Ports are decoded on all 16 address bits. A write to any other I/O address, such as $7FFE or $00FD, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address bus |
| data_i | input | 8 | CPU data bus for I/O writes |
| iorq_ni | input | 1 | I/O request, active low |
| mreq_ni | input | 1 | Memory request, active low |
| m1_ni | input | 1 | Opcode fetch cycle, active low |
| wr_ni | input | 1 | Write strobe, active low |
| phys_addr_o | output | 23 | Physical RAM address |
| boot_ce_o | output | 1 | Chip-enable for the bootloader overlay ROM |
| trap_o | output | 1 | Services-vector trap hit |

## Verification
Two functions can act in the same cycle, and the bench provokes both cases:
- The NMI-vector fetch at $0066 arms the context switch while the bootloader overlay is still active. The bench issues that fetch right after reset and judges it twice. In that cycle `boot_ce_o` must stay high. After the $44DF write, a plain read of $0000 must land in bank 36.
- The $0066 fetch itself must already see bank 36 in the cycle it occurs, before the context flag has been clocked.

// File: rtl/zxm_pkg.sv
package zxm_pkg;
  localparam logic [15:0] PORT_MEMCTL  = 16'h7FFD;
  localparam logic [15:0] PORT_SPECIAL = 16'h1FFD;
  localparam logic [15:0] PORT_FAST    = 16'h54DF;
  localparam logic [15:0] PORT_FASTHI  = 16'h64DF;
  localparam logic [15:0] PORT_LOCK    = 16'h44DF;
  localparam logic [15:0] PORT_FLAGS   = 16'h34DF;
  localparam logic [15:0] VEC_TRAP     = 16'h0025;
  localparam logic [15:0] VEC_NMI      = 16'h0066;

  // all-RAM layout per config and segment
  function automatic logic [2:0] special_bank(input logic [1:0] cfg, input logic [1:0] seg);
    logic [2:0] b;
    case (cfg)
      2'd0:    b = {1'b0, seg};
      2'd1:    b = {1'b1, seg};
      2'd2:    b = (seg == 2'd3) ? 3'd3 : {1'b1, seg};
      default: b = (seg == 2'd3) ? 3'd3 : (seg == 2'd1) ? 3'd7 : {1'b1, seg};
    endcase
    return b;
  endfunction
endpackage

// File: rtl/zxm_port_regs.sv
module zxm_port_regs
  import zxm_pkg::*;
#(
  parameter int FP_W  = 6,
  parameter int MSB_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             io_wr_i,
  input  logic [15:0]      port_i,
  input  logic [7:0]       data_i,
  output logic [2:0]       ram_bank_o,
  output logic             rom_lo_o,
  output logic             special_o,
  output logic [1:0]       cfg_o,
  output logic             fp_en_o,
  output logic [FP_W-1:0]  fp_bank_o,
  output logic [MSB_W-1:0] msb_o,
  output logic             lock_wr_o,
  output logic             flag_wr_o
);
  localparam int FP_EN_BIT = 7;

  logic [2:0]       ram_bank_q;
  logic             rom_lo_q, lock_q, special_q, fp_en_q;
  logic [1:0]       cfg_q;
  logic [FP_W-1:0]  fp_bank_q;
  logic [MSB_W-1:0] msb_q;
  logic             hit_memctl, hit_special, hit_fast, hit_fasthi;
  logic             unused_data;

  assign hit_memctl  = io_wr_i && (port_i == PORT_MEMCTL);
  assign hit_special = io_wr_i && (port_i == PORT_SPECIAL);
  assign hit_fast    = io_wr_i && (port_i == PORT_FAST);
  assign hit_fasthi  = io_wr_i && (port_i == PORT_FASTHI);
  assign lock_wr_o   = io_wr_i && (port_i == PORT_LOCK);
  assign flag_wr_o   = io_wr_i && (port_i == PORT_FLAGS);
  assign unused_data = ^{data_i[6], data_i[3]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_bank_q <= '0;
      rom_lo_q   <= 1'b0;
      lock_q     <= 1'b0;
      special_q  <= 1'b0;
      cfg_q      <= '0;
      fp_en_q    <= 1'b0;
      fp_bank_q  <= '0;
      msb_q      <= '0;
    end else begin
      if (hit_memctl && !lock_q) begin
        ram_bank_q <= data_i[2:0];
        rom_lo_q   <= data_i[4];
        lock_q     <= data_i[5];
      end
      if (hit_special && !lock_q) begin
        special_q <= data_i[0];
        cfg_q     <= data_i[2:1];
      end
      if (hit_fast) begin
        fp_en_q   <= data_i[FP_EN_BIT];
        fp_bank_q <= data_i[FP_W-1:0];
      end
      if (hit_fasthi) msb_q <= data_i[MSB_W-1:0];
    end
  end

  assign ram_bank_o = ram_bank_q;
  assign rom_lo_o   = rom_lo_q;
  assign special_o  = special_q;
  assign cfg_o      = cfg_q;
  assign fp_en_o    = fp_en_q;
  assign fp_bank_o  = fp_bank_q;
  assign msb_o      = msb_q;

  assert_lock_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> ($stable(ram_bank_q) && $stable(rom_lo_q) && $stable(special_q) && $stable(cfg_q)));
endmodule

// File: rtl/zxm_ctx_ctrl.sv
module zxm_ctx_ctrl
  import zxm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        lock_wr_i,
  input  logic        flag_wr_i,
  input  logic        bit0_i,
  input  logic        fetch_i,
  input  logic [15:0] addr_i,
  output logic        boot_on_o,
  output logic        ctx_on_o,
  output logic        trap_o
);
  logic boot_q, trap_en_q, ctx_q, nmi_hit;

  assign nmi_hit = fetch_i && (addr_i == VEC_NMI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q    <= 1'b1;
      trap_en_q <= 1'b0;
      ctx_q     <= 1'b0;
    end else begin
      if (lock_wr_i) begin
        boot_q    <= 1'b0;
        trap_en_q <= bit0_i;
      end
      if (flag_wr_i)    ctx_q <= bit0_i;
      else if (nmi_hit) ctx_q <= 1'b1;
    end
  end

  // vector fetch sees the swapped ROM in its own cycle
  assign ctx_on_o  = ctx_q || nmi_hit;
  assign boot_on_o = boot_q;
  assign trap_o    = trap_en_q && fetch_i && (addr_i == VEC_TRAP);

  assert_boot_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_q |=> !boot_q);
  assert_trap_en_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(trap_en_q) |-> $past(lock_wr_i));
  assert_ctx_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctx_q) |-> $past(flag_wr_i && !bit0_i));
endmodule

// File: rtl/zxm_addr_map.sv
module zxm_addr_map
  import zxm_pkg::*;
#(
  parameter int FP_W     = 6,
  parameter int MSB_W    = 3,
  parameter int OFFS_W   = 14,
  parameter int ROM_BASE = 32,
  parameter int CTX_ROM  = 4
) (
  input  logic [15:0]               addr_i,
  input  logic                      mem_i,
  input  logic [2:0]                ram_bank_i,
  input  logic                      rom_lo_i,
  input  logic                      special_i,
  input  logic [1:0]                cfg_i,
  input  logic                      fp_en_i,
  input  logic [FP_W-1:0]           fp_bank_i,
  input  logic [MSB_W-1:0]          msb_i,
  input  logic                      boot_on_i,
  input  logic                      ctx_on_i,
  output logic [FP_W+MSB_W+OFFS_W-1:0] phys_o,
  output logic                      boot_ce_o
);
  localparam int BANK_W = FP_W + MSB_W;

  logic [1:0]        seg;
  logic [BANK_W-1:0] bank;

  assign seg = addr_i[15:14];

  always_comb begin
    if (seg == 2'd0 && ctx_on_i)
      bank = BANK_W'(ROM_BASE + CTX_ROM);
    else if (seg == 2'd3 && fp_en_i)
      bank = {msb_i, fp_bank_i};
    else if (special_i)
      bank = BANK_W'(special_bank(cfg_i, seg));
    else begin
      case (seg)
        2'd0:    bank = BANK_W'(ROM_BASE) + BANK_W'({cfg_i[1], rom_lo_i});
        2'd1:    bank = BANK_W'(5);
        2'd2:    bank = BANK_W'(2);
        default: bank = BANK_W'(ram_bank_i);
      endcase
    end
  end

  assign phys_o    = {bank, addr_i[OFFS_W-1:0]};
  assign boot_ce_o = boot_on_i && mem_i && (seg == 2'd0);
endmodule

// File: rtl/zxm_bank_mapper.sv
module zxm_bank_mapper
  import zxm_pkg::*;
#(
  parameter int FP_W     = 6,
  parameter int MSB_W    = 3,
  parameter int OFFS_W   = 14,
  parameter int ROM_BASE = 32,
  parameter int CTX_ROM  = 4,
  localparam int PA_W    = FP_W + MSB_W + OFFS_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [15:0]     addr_i,
  input  logic [7:0]      data_i,
  input  logic            iorq_ni,
  input  logic            mreq_ni,
  input  logic            m1_ni,
  input  logic            wr_ni,
  output logic [PA_W-1:0] phys_addr_o,
  output logic            boot_ce_o,
  output logic            trap_o
);
  logic             io_wr, fetch, mem;
  logic [2:0]       ram_bank;
  logic             rom_lo, special, fp_en, lock_wr, flag_wr, boot_on, ctx_on;
  logic [1:0]       cfg;
  logic [FP_W-1:0]  fp_bank;
  logic [MSB_W-1:0] msb;

  assign io_wr = !iorq_ni && !wr_ni && m1_ni;
  assign mem   = !mreq_ni;
  assign fetch = !mreq_ni && !m1_ni;

  zxm_port_regs #(.FP_W(FP_W), .MSB_W(MSB_W)) u_regs (
    .clk_i, .rst_ni, .io_wr_i(io_wr), .port_i(addr_i), .data_i,
    .ram_bank_o(ram_bank), .rom_lo_o(rom_lo), .special_o(special), .cfg_o(cfg),
    .fp_en_o(fp_en), .fp_bank_o(fp_bank), .msb_o(msb),
    .lock_wr_o(lock_wr), .flag_wr_o(flag_wr)
  );

  zxm_ctx_ctrl u_ctx (
    .clk_i, .rst_ni, .lock_wr_i(lock_wr), .flag_wr_i(flag_wr), .bit0_i(data_i[0]),
    .fetch_i(fetch), .addr_i, .boot_on_o(boot_on), .ctx_on_o(ctx_on), .trap_o
  );

  zxm_addr_map #(.FP_W(FP_W), .MSB_W(MSB_W), .OFFS_W(OFFS_W),
                 .ROM_BASE(ROM_BASE), .CTX_ROM(CTX_ROM)) u_map (
    .addr_i, .mem_i(mem), .ram_bank_i(ram_bank), .rom_lo_i(rom_lo), .special_i(special),
    .cfg_i(cfg), .fp_en_i(fp_en), .fp_bank_i(fp_bank), .msb_i(msb),
    .boot_on_i(boot_on), .ctx_on_i(ctx_on), .phys_o(phys_addr_o), .boot_ce_o
  );

  assert_boot_ce_rom_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_ce_o |-> (addr_i[15:14] == 2'b00 && !mreq_ni));
  assert_seg1_bank5_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreq_ni && addr_i[15:14] == 2'b01 && !special)
      |-> (phys_addr_o[PA_W-1:OFFS_W] == (FP_W+MSB_W)'(5)));
endmodule

// File: tb/zxm_bank_mapper_tb.sv
module zxm_bank_mapper_tb;
  localparam int CLK_P = 10;
  localparam int PA_W  = 23;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic [15:0]     addr = '0;
  logic [7:0]      data = '0;
  logic            iorq_n = 1'b1, mreq_n = 1'b1, m1_n = 1'b1, wr_n = 1'b1;
  logic [PA_W-1:0] phys;
  logic            boot_ce, trap;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  zxm_bank_mapper u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data), .iorq_ni(iorq_n),
    .mreq_ni(mreq_n), .m1_ni(m1_n), .wr_ni(wr_n), .phys_addr_o(phys),
    .boot_ce_o(boot_ce), .trap_o(trap)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic io_wr(input logic [15:0] p, input logic [7:0] v);
    @(negedge clk); addr = p; data = v; iorq_n = 1'b0; wr_n = 1'b0;
    @(negedge clk); iorq_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic mem(input logic [15:0] a, input bit m1, input int exp_bank,
                     input bit exp_ce, input string req);
    int exp_pa;
    @(negedge clk); addr = a; mreq_n = 1'b0; m1_n = !m1; #1;
    chk(boot_ce == exp_ce, {req, " ce"}, int'(boot_ce), int'(exp_ce));
    if (!exp_ce) begin
      exp_pa = exp_bank * 16384 + int'(a[13:0]);
      chk(int'(phys) == exp_pa, {req, " addr"}, int'(phys), exp_pa);
    end
    @(negedge clk); mreq_n = 1'b1; m1_n = 1'b1;
  endtask

  task automatic fetch_trap(input logic [15:0] a, input bit m1, input bit exp, input string req);
    @(negedge clk); addr = a; mreq_n = 1'b0; m1_n = !m1; #1;
    chk(trap == exp, req, int'(trap), int'(exp));
    @(negedge clk); mreq_n = 1'b1; m1_n = 1'b1;
  endtask

  function automatic int tab(input int cfg, input int seg);
    case (cfg)
      0: return seg;
      1: return 4 + seg;
      2: return (seg == 3) ? 3 : 4 + seg;
      default: return (seg == 3) ? 3 : (seg == 1) ? 7 : 4 + seg;
    endcase
  endfunction

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    mem(16'h0000, 0, 0, 1, "R1 overlay");
    mem(16'h4000, 0, 5, 0, "R1 outside overlay");
    mem(16'hC000, 0, 0, 0, "R1 paging zero");
    fetch_trap(16'h0025, 1, 0, "R1 trap off");
    // R11 partial decode ignored
    io_wr(16'h7FFE, 8'h07);
    mem(16'hC000, 0, 0, 0, "R11 7FFE");
    io_wr(16'h00FD, 8'h03);
    mem(16'hC000, 0, 0, 0, "R11 00FD");
    // R2 normal paging sweep
    for (int b = 0; b < 8; b++) begin
      io_wr(16'h7FFD, 8'(b));
      mem(16'hC000 + 16'(b * 16'h0111), 0, b, 0, "R2 seg3");
      mem(16'h4000 + 16'(b), 0, 5, 0, "R2 seg1");
      mem(16'h8000 + 16'(b), 0, 2, 0, "R2 seg2");
    end
    // R7 lockout
    io_wr(16'h44DF, 8'h00);
    mem(16'h0000, 0, 32, 0, "R7 overlay gone");
    fetch_trap(16'h0025, 1, 0, "R8 D0 clear");
    // R3 ROM select
    for (int r = 0; r < 4; r++) begin
      io_wr(16'h1FFD, 8'((r >> 1) << 2));
      io_wr(16'h7FFD, 8'(((r & 1) << 4) | 7));
      mem(16'h1234, 0, 32 + r, 0, "R3 rom");
    end
    // R5 special mode
    for (int c = 0; c < 4; c++) begin
      io_wr(16'h1FFD, 8'((c << 1) | 1));
      for (int s = 0; s < 4; s++)
        mem(16'(s << 14) | 16'h0ABC, 0, tab(c, s), 0, "R5 special");
    end
    io_wr(16'h1FFD, 8'h00);
    // R6 fast paging sweep
    io_wr(16'h7FFD, 8'h03);
    for (int m = 0; m < 8; m++)
      for (int f = 0; f < 64; f++) begin
        io_wr(16'h54DF, 8'(8'h80 | f));
        io_wr(16'h64DF, 8'(m));
        mem(16'hC000 | 16'(f), 0, m * 64 + f, 0, "R6 fastpage");
      end
    io_wr(16'h54DF, 8'h05);
    mem(16'hC000, 0, 3, 0, "R6 disabled");
    mem(16'h4000, 0, 5, 0, "R6 seg1 untouched");
    // R8 trap
    io_wr(16'h44DF, 8'hAB);
    fetch_trap(16'h0025, 1, 1, "R8 trap hit");
    fetch_trap(16'h0025, 0, 0, "R8 non-M1");
    fetch_trap(16'h0026, 1, 0, "R8 other addr");
    io_wr(16'h44DF, 8'hAA);
    fetch_trap(16'h0025, 1, 0, "R8 disabled");
    mem(16'h0000, 0, 32, 0, "R7 stays off");
    // R9 context switch
    mem(16'h0066, 1, 36, 0, "R9 same cycle");
    mem(16'h0000, 0, 36, 0, "R9 held");
    io_wr(16'h7FFD, 8'h03);
    io_wr(16'h44DF, 8'h00);
    mem(16'h0000, 0, 36, 0, "R9 other writes");
    io_wr(16'h34DF, 8'h00);
    mem(16'h0000, 0, 32, 0, "R9 cleared");
    io_wr(16'h34DF, 8'h01);
    mem(16'h0010, 0, 36, 0, "R9 sw set");
    io_wr(16'h34DF, 8'h00);
    mem(16'h0066, 0, 32, 0, "R9 non-M1");
    mem(16'h0000, 0, 32, 0, "R9 not armed");
    // R10 ctx over special
    io_wr(16'h1FFD, 8'h01);
    io_wr(16'h34DF, 8'h01);
    mem(16'h0000, 0, 36, 0, "R10 ctx over special");
    mem(16'h4000, 0, 1, 0, "R10 special seg1");
    io_wr(16'h34DF, 8'h00);
    mem(16'h0000, 0, 0, 0, "R10 special rom area");
    io_wr(16'h1FFD, 8'h00);
    // R4 lock
    io_wr(16'h7FFD, 8'h24);
    mem(16'hC000, 0, 4, 0, "R4 locking write");
    io_wr(16'h7FFD, 8'h06);
    mem(16'hC000, 0, 4, 0, "R4 7FFD ignored");
    io_wr(16'h1FFD, 8'h01);
    mem(16'h4000, 0, 5, 0, "R4 1FFD ignored");
    mem(16'h0000, 0, 32, 0, "R4 rom kept");
    io_wr(16'h44DF, 8'hAB);
    // R1 second reset
    do_reset();
    mem(16'h0000, 0, 0, 1, "R1 overlay back");
    mem(16'h8000, 0, 2, 0, "R1 seg2");
    fetch_trap(16'h0025, 1, 0, "R1 trap reset");
    io_wr(16'h7FFD, 8'h06);
    mem(16'hC000, 0, 6, 0, "R4 lock cleared");
    // R10 NMI fetch while overlay on
    mem(16'h0066, 1, 0, 1, "R10 overlay wins");
    io_wr(16'h44DF, 8'h00);
    mem(16'h0000, 0, 36, 0, "R10 ctx armed");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule